// File: doc/BRIEF.md
# Audio serial clock generator

This block derives the bit clock and the left/right frame clock of a two-channel audio serial link from a faster module clock. One 16-bit control word selects the mode and the clock shape. As clock master the block drives both clock pins. As slave it releases the pins and follows clocks that another device supplies. In both modes it tells a neighbouring serializer which channel half is current, which bit of that half is on the line and whether that bit belongs to the sample word.

The bit clock ratio comes from a 4-bit code that selects one of a fixed set of ratios, not all of them powers of two. The length of each channel half comes from a 3-bit code and the sample width from a 2-bit code. A 2-bit format field places the sample word inside its half. The frame-clock polarity bit works the opposite way to the bit-clock polarity bit: with it set, the frame pin is low during the left half. A control write made while the block is master waits for the end of the current full frame, so the clock pins never show a shortened pulse.

Top module: `audio_clkgen`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to slave mode with the active control word cleared. After that edge bclk_o, lrck_o, bclk_oe, lrck_oe, frame_phase, bit_pos and word_active are all 0.
- R2: Control bits [12:9] select the bit-clock ratio. Codes 0 to 13 give module-clock ratios 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192, and codes 14 and 15 give 192. Every even ratio N gives a bit clock with period N cycles that is high for N/2 of them.
- R3: Control bits [8:6] hold a code k that sets L = 8*(k+1) bit clocks per channel half. bit_pos runs 0..L-1, and in master mode a full frame takes 2*L*N module cycles.
- R4: Control bit 14 inverts bclk_o. frame_phase is 0 for the left half. lrck_o equals frame_phase when bit 13 is 1 and equals its inverse when bit 13 is 0.
- R5: Control bit 15 set to 1 selects master mode: bclk_oe and lrck_oe are 1 and the block drives both clock pins. Bit 15 set to 0 selects slave mode: both enables are 0 and bclk_o and lrck_o are held at 0.
- R6: In slave mode each input passes through a two-stage synchronizer. frame_phase follows lrck_i XOR NOT bit13. bit_pos counts falling edges of (bclk_i XOR bit14) and returns to 0 whenever frame_phase changes. The outputs settle within 4 module cycles of an input change.
- R7: word_active is 1 when bit_pos lies in the sample window. The window length W comes from control bits [5:4]: code 0, 1, 2 and 3 give 8, 16, 20 and 24. Format bits [3:2] set the first bit S: S = 1 for code 0, S = L-W (or 0 if W exceeds L) for code 2, and S = 0 for codes 1 and 3. The window ends before min(S+W, L).
- R8: In master mode a write on cfg_wr is held until the right half of the current frame ends, and the new setting starts with a new left half. In slave mode a write takes effect on the next cycle.
- R9: With ratio code 0 in master mode, bclk_o is the module clock, with the bit-14 inversion applied, and bit_pos advances once per module cycle.
- R10: In master mode with a ratio of at least 2, frame_phase changes only in the cycle in which the uninverted bit clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word; bits [1:0] unused |
| bclk_i | input | 1 | Bit clock from the pin (slave mode) |
| lrck_i | input | 1 | Frame clock from the pin (slave mode) |
| bclk_o | output | 1 | Bit clock pin drive value |
| bclk_oe | output | 1 | Bit clock pin drive enable |
| lrck_o | output | 1 | Frame clock pin drive value |
| lrck_oe | output | 1 | Frame clock pin drive enable |
| frame_phase | output | 1 | Current channel half, 0 = left |
| bit_pos | output | 6 | Bit index inside the current half |
| word_active | output | 1 | Current bit lies in the sample window |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. That fixes slave-mode latency at three module cycles, so the bench can place its slave samples four cycles after each pin change. With the fixed code tables, the stimulus reaches both extreme half lengths (8 and 64 bits), the ratio-1 bypass, the remapped codes above 13, and the right-justified window clipped by a half shorter than the word. The longest frames stay within a few thousand cycles, so each configuration is measured over a whole frame.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  localparam int CFG_W   = 16;
  localparam int CFG_LSB = 2;
  localparam int FIELD_W = CFG_W - CFG_LSB;
  localparam int RATIO_W = 8;
  localparam int CNT_W   = RATIO_W - 1;
  localparam int LEN_W   = 7;
  localparam int POS_W   = LEN_W - 1;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_ALT   = 2'd3
  } fmt_e;

  // control word fields, most significant first, from bit 15 down to bit 2
  typedef struct packed {
    logic       master;
    logic       bclk_inv;
    logic       lrck_inv;
    logic [3:0] div_code;
    logic [2:0] flen_code;
    logic [1:0] wsize_code;
    logic [1:0] fmt;
  } cfg_t;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [3:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd0:    r = 8'd1;
      4'd1:    r = 8'd2;
      4'd2:    r = 8'd4;
      4'd3:    r = 8'd6;
      4'd4:    r = 8'd8;
      4'd5:    r = 8'd12;
      4'd6:    r = 8'd16;
      4'd7:    r = 8'd24;
      4'd8:    r = 8'd32;
      4'd9:    r = 8'd48;
      4'd10:   r = 8'd64;
      4'd11:   r = 8'd96;
      4'd12:   r = 8'd128;
      default: r = 8'd192;
    endcase
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] half_len_of(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    n = {{(LEN_W-3){1'b0}}, code} + 1'b1;
    return n << 3;
  endfunction

  function automatic logic [LEN_W-1:0] word_len_of(input logic [1:0] code);
    logic [LEN_W-1:0] w;
    case (code)
      2'd0:    w = 7'd8;
      2'd1:    w = 7'd16;
      2'd2:    w = 7'd20;
      default: w = 7'd24;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/audio_clkgen_cfg.sv
module audio_clkgen_cfg
  import audio_clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_fields,
  input  logic               frame_end,
  output cfg_t               act,
  output logic               apply
);

  cfg_t pend;
  logic pend_vld;

  // a master keeps its setting until the frame closes; a slave takes it at once
  assign apply = pend_vld && (!act.master || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_vld <= 1'b0;
      act      <= '0;
    end else begin
      if (apply) act <= pend;
      if (wr_en) begin
        pend     <= cfg_t'(wr_fields);
        pend_vld <= 1'b1;
      end else if (apply) begin
        pend_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audio_clkgen_div.sv
module audio_clkgen_div
  import audio_clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic               raw,
  output logic               tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic             is_one;
  logic             at_wrap;

  assign half    = ratio[RATIO_W-1:1];
  assign is_one  = (ratio == 8'd1);
  assign at_wrap = (cnt == half - 1'b1);
  // a bit period closes when the internal clock falls
  assign tick    = run && (is_one || (at_wrap && raw));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      cnt <= '0;
      raw <= 1'b0;
    end else if (!is_one) begin
      if (at_wrap) begin
        cnt <= '0;
        raw <= ~raw;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/audio_clkgen_sync.sv
module audio_clkgen_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_prev <= '0;
    else        q_prev <= stage[STAGES-1];
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/audio_clkgen_frame.sv
module audio_clkgen_frame
  import audio_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             master,
  input  logic             tick,
  input  logic [LEN_W-1:0] half_len,
  input  logic             ext_phase,
  input  logic             ext_fall,
  output logic [POS_W-1:0] pos,
  output logic             phase,
  output logic             frame_end
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic last_bit;

  assign last_bit  = ({1'b0, pos} == half_len - 1'b1);
  assign frame_end = master && tick && last_bit && phase;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pos   <= '0;
      phase <= 1'b0;
    end else if (master) begin
      if (tick) begin
        if (last_bit) begin
          pos   <= '0;
          phase <= ~phase;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end else begin
      // a frame edge from the pins outranks a bit edge in the same cycle
      if (ext_phase != phase) begin
        phase <= ext_phase;
        pos   <= '0;
      end else if (ext_fall && pos != POS_MAX) begin
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             bclk_i,
  input  logic             lrck_i,
  output logic             bclk_o,
  output logic             bclk_oe,
  output logic             lrck_o,
  output logic             lrck_oe,
  output logic             frame_phase,
  output logic [POS_W-1:0] bit_pos,
  output logic             word_active
);

  cfg_t               act;
  logic               apply;
  logic               frame_end;
  logic [RATIO_W-1:0] ratio;
  logic [LEN_W-1:0]   half_len;
  logic [LEN_W-1:0]   word_len;
  logic               bclk_raw;
  logic               div_tick;
  logic [1:0]         pin_sync;
  logic [1:0]         pin_prev;
  logic               ext_b_now;
  logic               ext_b_old;
  logic               ext_fall;
  logic               ext_phase;
  logic [LEN_W-1:0]   win_start;
  logic [LEN_W-1:0]   win_sum;
  logic [LEN_W-1:0]   win_end;
  logic [LEN_W-1:0]   pos_wide;
  logic               cfg_unused;

  assign cfg_unused = ^cfg_wdata[CFG_LSB-1:0];

  assign ratio    = ratio_of(act.div_code);
  assign half_len = half_len_of(act.flen_code);
  assign word_len = word_len_of(act.wsize_code);

  audio_clkgen_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_fields (cfg_wdata[CFG_W-1:CFG_LSB]),
    .frame_end (frame_end),
    .act       (act),
    .apply     (apply)
  );

  audio_clkgen_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (act.master),
    .restart (apply),
    .ratio   (ratio),
    .raw     (bclk_raw),
    .tick    (div_tick)
  );

  audio_clkgen_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({bclk_i, lrck_i}),
    .q      (pin_sync),
    .q_prev (pin_prev)
  );

  assign ext_b_now = pin_sync[1] ^ act.bclk_inv;
  assign ext_b_old = pin_prev[1] ^ act.bclk_inv;
  assign ext_fall  = ext_b_old && !ext_b_now;
  // frame invert bit reads backwards: set means left half low
  assign ext_phase = pin_sync[0] ^ ~act.lrck_inv;

  audio_clkgen_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (apply),
    .master    (act.master),
    .tick      (div_tick),
    .half_len  (half_len),
    .ext_phase (ext_phase),
    .ext_fall  (ext_fall),
    .pos       (bit_pos),
    .phase     (frame_phase),
    .frame_end (frame_end)
  );

  // sample window inside one channel half
  always_comb begin
    case (fmt_e'(act.fmt))
      FMT_I2S:   win_start = 7'd1;
      FMT_RIGHT: win_start = (half_len > word_len) ? half_len - word_len : '0;
      default:   win_start = '0;
    endcase
    win_sum  = win_start + word_len;
    win_end  = (win_sum < half_len) ? win_sum : half_len;
  end

  assign pos_wide    = {1'b0, bit_pos};
  assign word_active = (pos_wide >= win_start) && (pos_wide < win_end);

  assign bclk_oe = act.master;
  assign lrck_oe = act.master;
  assign bclk_o  = act.master && (((ratio == 8'd1) ? clk : bclk_raw) ^ act.bclk_inv);
  assign lrck_o  = act.master && (frame_phase ^ ~act.lrck_inv);

endmodule

// File: rtl/audio_clkgen_checker.sv
module audio_clkgen_checker
  import audio_clkgen_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               act_master,
  input logic [FIELD_W-1:0] act_word,
  input logic [3:0]         div_code,
  input logic               bclk_raw,
  input logic               frame_end,
  input logic [POS_W-1:0]   bit_pos,
  input logic               frame_phase,
  input logic               bclk_oe,
  input logic               lrck_oe,
  input logic               bclk_o,
  input logic               lrck_o
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (bit_pos == '0 && !frame_phase && !bclk_oe && !lrck_oe)); // R1

  AST_BCLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_master && div_code >= 4'd2 && $rose(bclk_raw)) |=> bclk_raw); // R2

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_master && !$stable(bit_pos) && bit_pos != '0)
      |-> (bit_pos == $past(bit_pos) + 1'b1)); // R3

  AST_SLAVE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !act_master |-> (!bclk_oe && !bclk_o && !lrck_o)); // R5

  AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (act_master && !frame_end) |=> $stable(act_word)); // R8

  AST_PHASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_master && $past(act_master) && act_word == $past(act_word)
      && div_code != 4'd0 && !$stable(frame_phase)) |-> $fell(bclk_raw)); // R10

endmodule

bind audio_clkgen audio_clkgen_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .act_master  (act.master),
  .act_word    (act),
  .div_code    (act.div_code),
  .bclk_raw    (bclk_raw),
  .frame_end   (frame_end),
  .bit_pos     (bit_pos),
  .frame_phase (frame_phase),
  .bclk_oe     (bclk_oe),
  .lrck_oe     (lrck_oe),
  .bclk_o      (bclk_o),
  .lrck_o      (lrck_o)
);

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;

  localparam int WATCHDOG = 190000;

  typedef struct packed {
    logic [15:0] cfg;
    int          frame;
    int          act;
    int          lhalf;
  } vec_t;

  // master, normal frame polarity; frame = 2*L*N, act = 2*bits*N
  localparam vec_t VECS [9] = '{
    '{16'hA254,   64,   64, 16},  // N2  L16 W16 left
    '{16'hA600,   96,   84,  8},  // N6  L8  W8  i2s: 7 bits
    '{16'hAAF8,  768,  576, 32},  // N12 L32 W24 right
    '{16'hA478,  128,  128, 16},  // N4  L16 W24 right, clipped
    '{16'hBC10, 3072, 2688,  8},  // code 14 -> N192, L8 i2s
    '{16'hBA2C, 3072, 3072,  8},  // N192 L8 W20 alt format
    '{16'hAEA4, 1152,  960, 24},  // N24 L24 W20 left
    '{16'hA9D8, 1024,  256, 64},  // N8  L64 W16 right
    '{16'hB450, 2048, 1920, 16}   // N64 L16 W16 i2s
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        bclk_i = 1'b0;
  logic        lrck_i = 1'b0;
  logic        bclk_o, bclk_oe, lrck_o, lrck_oe, frame_phase, word_active;
  logic [5:0]  bit_pos;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  audio_clkgen u_audio_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .bclk_i      (bclk_i),
    .lrck_i      (lrck_i),
    .bclk_o      (bclk_o),
    .bclk_oe     (bclk_oe),
    .lrck_o      (lrck_o),
    .lrck_oe     (lrck_oe),
    .frame_phase (frame_phase),
    .bit_pos     (bit_pos),
    .word_active (word_active)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // measure one full frame between the second and third rise of lrck_o
  task automatic measure(output int cyc, output int hi, output int actc, output int maxp);
    int   rises;
    logic prev;
    logic rose;
    cyc = 0; hi = 0; actc = 0; maxp = 0; rises = 0;
    @(negedge clk);
    prev = lrck_o;
    while (rises < 2) begin
      @(negedge clk);
      if (lrck_o && !prev) rises++;
      prev = lrck_o;
    end
    do begin
      cyc++;
      hi   += int'(bclk_o);
      actc += int'(word_active);
      if (int'(bit_pos) > maxp) maxp = int'(bit_pos);
      @(negedge clk);
      rose = lrck_o && !prev;
      prev = lrck_o;
    end while (!rose);
  endtask

  task automatic ext_bit();
    bclk_i = 1'b1;
    wait_cycles(4);
    bclk_i = 1'b0;
    wait_cycles(4);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int cyc, hi, actc, maxp, run;
    logic prev_ph;

    // reset state
    wait_cycles(3);
    check("R1 bclk_o", int'(bclk_o), 0);
    check("R1 lrck_o", int'(lrck_o), 0);
    check("R1 oe", int'(bclk_oe) + int'(lrck_oe), 0);
    check("R1 bit_pos", int'(bit_pos), 0);
    check("R1 frame_phase", int'(frame_phase), 0);
    check("R1 word_active", int'(word_active), 0);
    rst_n = 1'b1;
    wait_cycles(2);

    // master table
    for (int i = 0; i < 9; i++) begin
      cfg_write(VECS[i].cfg);
      measure(cyc, hi, actc, maxp);
      check($sformatf("R2/R3 frame cycles v%0d", i), cyc, VECS[i].frame);
      check($sformatf("R2 bclk high cycles v%0d", i), hi, VECS[i].frame / 2);
      check($sformatf("R7 active cycles v%0d", i), actc, VECS[i].act);
      check($sformatf("R3 max bit_pos v%0d", i), maxp, VECS[i].lhalf - 1);
      check($sformatf("R5 oe v%0d", i), int'(bclk_oe) + int'(lrck_oe), 2);
    end

    // R8: a write in mid frame waits for the frame end
    cfg_write(16'hA254);
    measure(cyc, hi, actc, maxp);
    // the last measure sample was a fresh rise: right half starts now
    cfg_wr    = 1'b1;
    cfg_wdata = 16'hA654;
    run = 1;
    @(negedge clk);
    cfg_wr = 1'b0;
    while (lrck_o) begin
      run++;
      @(negedge clk);
    end
    check("R8 old right half length", run, 32);
    while (!lrck_o) @(negedge clk);
    run = 0;
    while (lrck_o) begin
      run++;
      @(negedge clk);
    end
    check("R8 new right half length", run, 96);

    // R4 / R10: both polarities flipped
    cfg_write(16'hC400);
    wait_cycles(600);
    prev_ph = frame_phase;
    @(negedge clk);
    while (frame_phase == prev_ph) begin
      prev_ph = frame_phase;
      @(negedge clk);
    end
    check("R4 lrck_o inverted", int'(lrck_o), int'(!frame_phase));
    check("R10 bclk falls with frame edge (inverted pin high)", int'(bclk_o), 1);
    wait_cycles(1);
    check("R4 bclk_o inverted one cycle after fall", int'(bclk_o), 1);

    // R9: ratio 1 bypass
    cfg_write(16'hA010);
    wait_cycles(100);
    while (lrck_o) @(negedge clk);
    while (!lrck_o) @(negedge clk);
    run = 0;
    while (lrck_o) begin
      run++;
      @(negedge clk);
    end
    check("R9 half length in module cycles", run, 8);
    check("R9 bclk_o low with clk low", int'(bclk_o), 0);
    @(posedge clk);
    #5;
    check("R9 bclk_o high with clk high", int'(bclk_o), 1);

    // R5 / R6: slave mode
    bclk_i = 1'b0;
    lrck_i = 1'b0;
    cfg_write(16'h2054);
    wait_cycles(30);
    check("R5 slave oe", int'(bclk_oe) + int'(lrck_oe), 0);
    check("R5 slave pins low", int'(bclk_o) + int'(lrck_o), 0);
    check("R6 slave phase left", int'(frame_phase), 0);
    for (int k = 0; k < 5; k++) ext_bit();
    check("R6 slave bit count", int'(bit_pos), 5);
    bclk_i = 1'b1;
    wait_cycles(4);
    bclk_i = 1'b0;
    lrck_i = 1'b1;
    wait_cycles(4);
    check("R6 slave phase right", int'(frame_phase), 1);
    check("R6 frame edge clears count", int'(bit_pos), 0);
    for (int k = 0; k < 3; k++) ext_bit();
    check("R6 count after frame edge", int'(bit_pos), 3);
    check("R7 slave window", int'(word_active), 1);
    cfg_write(16'h0054);
    wait_cycles(4);
    check("R6/R8 slave frame invert taken at once", int'(frame_phase), 0);
    check("R6 slave count after rewrite", int'(bit_pos), 0);

    // R1: reset while running as master
    cfg_write(16'hA010);
    wait_cycles(20);
    check("R5 master oe", int'(bclk_oe) + int'(lrck_oe), 2);
    rst_n = 1'b0;
    wait_cycles(1);
    check("R1 mid-run oe", int'(bclk_oe) + int'(lrck_oe), 0);
    check("R1 mid-run pins", int'(bclk_o) + int'(lrck_o), 0);
    check("R1 mid-run bit_pos", int'(bit_pos), 0);
    check("R1 mid-run phase", int'(frame_phase), 0);
    rst_n = 1'b1;
    wait_cycles(2);

    summary();
    $finish;
  end

endmodule